// File: doc/BRIEF.md
# CAN receive buffer control register

This block holds the control and command word of one CAN receive message buffer. A host writes and reads it as a single 32-bit register. A hardware event interface on the controller side sets status flags. The host sets up the frame-format fields and the buffer options. Each of the two field groups has its own write-gate bit in the written word, so one store can change one group and leave the other alone.

One status flag serves two purposes. When automatic remote-frame reply is off, the flag reports that a new message has landed in the buffer. When automatic reply is on, it reports that the automatic reply has gone out. The host clears the flag by writing 1 to it. A second flag tracks an outstanding reply request. A third flag lets the host ask for that request to be cancelled. The transmit side clears both of these together when the reply is either withdrawn or wins arbitration.

The outputs drive the buffer enable, the link to the next buffer, the reply enable, the frame-format fields, a saturated byte count and an interrupt request.

Top module: `can_rxbuf_ctrl`

## Requirements
- R1: After reset, the readback word is 0x00000000 and every flag, option and frame output is 0.
- R2: A write with bit 23 set loads bits 21:16 into RTR (bit 21), IDE (bit 20) and DLC (bits 19:16). A write with bit 23 clear leaves those fields unchanged.
- R3: A write with bit 7 set loads bits 6:3 into link (6), interrupt enable (5), auto reply enable (4) and buffer enable (3). A write with bit 7 clear leaves them unchanged. The bit 7 gate is independent of the bit 23 gate.
- R4: Readback returns 0 in bits 31:24, 23, 22, 15:8 and 7, whatever was written.
- R5: The byte-count output equals DLC for codes 0 to 8 and equals 8 for codes 9 to 15.
- R6: With auto reply disabled, a message-stored pulse sets bit 0, and a reply-sent pulse has no effect on it.
- R7: With auto reply enabled, a reply-sent pulse sets bit 0, and a message-stored pulse has no effect on it.
- R8: A write of 1 to bit 0 clears it, and a write of 0 has no effect. A set event in the same cycle as the clear wins.
- R9: A write of 1 to bit 2 sets the abort request. A reply-done pulse clears bit 2 and bit 1 in the same cycle.
- R10: A reply-pending pulse sets bit 1. Host writes to bit 1 have no effect on it.
- R11: The interrupt output is high exactly while bit 0 and the interrupt enable are both set.
- R12: The buffer-enable, link and reply-enable outputs follow the stored bits 3, 6 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Host write strobe |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Readback word |
| msg_stored_i | input | 1 | Pulse: a message was stored in the buffer |
| reply_sent_i | input | 1 | Pulse: the automatic reply was sent |
| reply_pend_set_i | input | 1 | Pulse: a reply request became outstanding |
| reply_done_i | input | 1 | Pulse: the reply was removed or won arbitration |
| buf_en_o | output | 1 | Buffer enable |
| link_o | output | 1 | Buffer is linked to the next one |
| reply_en_o | output | 1 | Automatic remote reply enable |
| rtr_o | output | 1 | Remote frame bit |
| ide_o | output | 1 | Extended identifier bit |
| dlc_o | output | 4 | Stored data length code |
| data_len_o | output | 4 | Byte count, saturated at 8 |
| abort_req_o | output | 1 | Reply cancellation request |
| reply_pend_o | output | 1 | Reply request outstanding |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The write gates are tested with words that set one gate, the other, both and neither. This separates an unchanged field from one that was rewritten with its old value. The status flag is driven by both event sources under both settings of the reply enable, which shows whether the source is selected correctly. A set pulse that coincides with an acknowledge shows the priority between them. The reply flags are tested by a reply-done pulse with and without a pending abort, and by host writes to the hardware-owned bit.

// File: rtl/can_rxbuf_pkg.sv
package can_rxbuf_pkg;
  localparam int REG_W     = 32;
  localparam int DLC_W     = 4;
  localparam int MAX_BYTES = 8;

  // bit positions the host software relies on
  localparam int WP_CTL_B  = 23;
  localparam int CTL_LSB   = 16;
  localparam int CTL_MSB   = 21;
  localparam int WP_OPT_B  = 7;
  localparam int OPT_LSB   = 3;
  localparam int OPT_MSB   = 6;
  localparam int ABORT_B   = 2;
  localparam int PEND_B    = 1;
  localparam int AVAIL_B   = 0;

  typedef struct packed {
    logic             rtr;
    logic             ide;
    logic [DLC_W-1:0] dlc;
  } frame_ctl_t;

  typedef struct packed {
    logic link;
    logic rxie;
    logic rren;
    logic ben;
  } buf_opt_t;
endpackage

// File: rtl/rxbuf_cfg_regs.sv
module rxbuf_cfg_regs
  import can_rxbuf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output frame_ctl_t       ctl_o,
  output buf_opt_t         opt_o
);
  frame_ctl_t ctl_q;
  buf_opt_t   opt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      opt_q <= '0;
    end else if (wr_i) begin
      if (wdata_i[WP_CTL_B]) ctl_q <= frame_ctl_t'(wdata_i[CTL_MSB:CTL_LSB]);
      if (wdata_i[WP_OPT_B]) opt_q <= buf_opt_t'(wdata_i[OPT_MSB:OPT_LSB]);
    end
  end

  assign ctl_o = ctl_q;
  assign opt_o = opt_q;

  p_ctl_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[WP_CTL_B]) |=> $stable(ctl_q));
  p_opt_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[WP_OPT_B]) |=> $stable(opt_q));
  p_idle_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(opt_q) && $stable(ctl_q)));
endmodule

// File: rtl/rxbuf_len_sat.sv
module rxbuf_len_sat #(
  parameter int DLC_W     = 4,
  parameter int MAX_BYTES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DLC_W-1:0] dlc_i,
  output logic [DLC_W-1:0] len_o
);
  localparam logic [DLC_W-1:0] CAP = DLC_W'(MAX_BYTES);

  assign len_o = (dlc_i > CAP) ? CAP : dlc_i;

  p_len_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_o <= CAP) && ((dlc_i <= CAP) -> (len_o == dlc_i)));
endmodule

// File: rtl/rxbuf_flags.sv
module rxbuf_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rren_i,
  input  logic msg_stored_i,
  input  logic reply_sent_i,
  input  logic pend_set_i,
  input  logic reply_done_i,
  input  logic ack_i,
  input  logic abort_wr_i,
  output logic avail_o,
  output logic pend_o,
  output logic abort_o
);
  logic avail_q, pend_q, abort_q;
  logic set_evt;

  // flag source depends on auto reply mode
  assign set_evt = rren_i ? reply_sent_i : msg_stored_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avail_q <= 1'b0;
      pend_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (set_evt)    avail_q <= 1'b1;
      else if (ack_i) avail_q <= 1'b0;

      if (reply_done_i)    pend_q <= 1'b0;
      else if (pend_set_i) pend_q <= 1'b1;

      if (reply_done_i)    abort_q <= 1'b0;
      else if (abort_wr_i) abort_q <= 1'b1;
    end
  end

  assign avail_o = avail_q;
  assign pend_o  = pend_q;
  assign abort_o = abort_q;

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_evt |=> avail_q);
  p_ack_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_evt) |=> !avail_q);
  p_done_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply_done_i |=> (!abort_q && !pend_q));
  p_pend_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_set_i && !reply_done_i) |=> pend_q);
  p_pend_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_set_i && !reply_done_i) |=> $stable(pend_q));
endmodule

// File: rtl/can_rxbuf_ctrl.sv
module can_rxbuf_ctrl
  import can_rxbuf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             msg_stored_i,
  input  logic             reply_sent_i,
  input  logic             reply_pend_set_i,
  input  logic             reply_done_i,
  output logic             buf_en_o,
  output logic             link_o,
  output logic             reply_en_o,
  output logic             rtr_o,
  output logic             ide_o,
  output logic [DLC_W-1:0] dlc_o,
  output logic [DLC_W-1:0] data_len_o,
  output logic             abort_req_o,
  output logic             reply_pend_o,
  output logic             irq_o
);
  frame_ctl_t ctl;
  buf_opt_t   opt;
  logic       avail, pend, abort;

  rxbuf_cfg_regs u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .ctl_o   (ctl),
    .opt_o   (opt)
  );

  rxbuf_flags u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rren_i       (opt.rren),
    .msg_stored_i (msg_stored_i),
    .reply_sent_i (reply_sent_i),
    .pend_set_i   (reply_pend_set_i),
    .reply_done_i (reply_done_i),
    .ack_i        (reg_wr_i && reg_wdata_i[AVAIL_B]),
    .abort_wr_i   (reg_wr_i && reg_wdata_i[ABORT_B]),
    .avail_o      (avail),
    .pend_o       (pend),
    .abort_o      (abort)
  );

  rxbuf_len_sat #(.DLC_W(DLC_W), .MAX_BYTES(MAX_BYTES)) u_len (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dlc_i  (ctl.dlc),
    .len_o  (data_len_o)
  );

  // gate bits and reserved bits read as zero
  always_comb begin
    reg_rdata_o                  = '0;
    reg_rdata_o[CTL_MSB:CTL_LSB] = ctl;
    reg_rdata_o[OPT_MSB:OPT_LSB] = opt;
    reg_rdata_o[ABORT_B]         = abort;
    reg_rdata_o[PEND_B]          = pend;
    reg_rdata_o[AVAIL_B]         = avail;
  end

  assign buf_en_o     = opt.ben;
  assign link_o       = opt.link;
  assign reply_en_o   = opt.rren;
  assign rtr_o        = ctl.rtr;
  assign ide_o        = ctl.ide;
  assign dlc_o        = ctl.dlc;
  assign abort_req_o  = abort;
  assign reply_pend_o = pend;
  assign irq_o        = avail & opt.rxie;

  p_irq_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (reg_rdata_o[AVAIL_B] && reg_rdata_o[5]));
  p_rsvd_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[31:22] == '0) && (reg_rdata_o[15:7] == '0));
endmodule

// File: tb/can_rxbuf_ctrl_tb_top.sv
module can_rxbuf_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        msg_st = 1'b0, rep_sent = 1'b0, pend_set = 1'b0, rep_done = 1'b0;
  logic        ben, lnk, ren, rtr, ide, abrt, pnd, irq;
  logic [3:0]  dlc, dlen;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  can_rxbuf_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .msg_stored_i(msg_st), .reply_sent_i(rep_sent),
    .reply_pend_set_i(pend_set), .reply_done_i(rep_done), .buf_en_o(ben),
    .link_o(lnk), .reply_en_o(ren), .rtr_o(rtr), .ide_o(ide), .dlc_o(dlc),
    .data_len_o(dlen), .abort_req_o(abrt), .reply_pend_o(pnd), .irq_o(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // inputs change on the falling edge, results are read on the next falling edge
  task automatic host_wr(input logic [31:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input logic m, input logic s, input logic p, input logic d);
    @(negedge clk); msg_st = m; rep_sent = s; pend_set = p; rep_done = d;
    @(negedge clk); msg_st = 0; rep_sent = 0; pend_set = 0; rep_done = 0;
  endtask

  task automatic t_reset();
    chk(rdata, 32'h0, "R1 readback");
    chk({ben, lnk, ren, rtr, ide, abrt, pnd, irq}, 8'h0, "R1 flags");
    chk({dlc, dlen}, 8'h0, "R1 length");
  endtask

  task automatic t_ctl_gate();
    host_wr(32'h00A5_0000);
    chk(rdata, 32'h0025_0000, "R2 gated load");
    chk({rtr, ide, dlc}, {1'b1, 1'b0, 4'd5}, "R2 outputs");
    host_wr(32'h0013_0000);
    chk(rdata, 32'h0025_0000, "R2 gate clear keeps");
  endtask

  task automatic t_opt_gate();
    host_wr(32'h0000_00F8);
    chk(rdata, 32'h0025_0078, "R3 gated load");
    chk({ben, lnk, ren}, 3'b111, "R12 outputs follow");
    host_wr(32'h0000_0000);
    chk(rdata, 32'h0025_0078, "R3 gate clear keeps");
    host_wr(32'h0000_0088);
    chk(rdata, 32'h0025_0008, "R3 independent of R2 gate");
    chk({ben, lnk, ren}, 3'b100, "R12 outputs after reload");
  endtask

  task automatic t_readback();
    host_wr(32'hFFFF_FFF8);
    chk(rdata, 32'h003F_0078, "R4 reserved and gate bits read 0");
    chk(dlen, 4'd8, "R5 code 15");
  endtask

  task automatic t_len();
    for (int d = 0; d < 16; d++) begin
      host_wr(32'h0080_0000 | (32'(d) << 16));
      chk(dlen, (d > 8) ? 4'd8 : 4'(d), "R5 saturation");
    end
  endtask

  task automatic t_msg_mode();
    host_wr(32'h0000_00A8);   // interrupt enable + buffer enable, auto reply off
    pulse(0, 1, 0, 0);
    chk(rdata[0], 1'b0, "R6 reply-sent ignored");
    pulse(1, 0, 0, 0);
    chk(rdata[0], 1'b1, "R6 message sets flag");
    chk(irq, 1'b1, "R11 irq raised");
  endtask

  task automatic t_ack();
    host_wr(32'h0000_0000);
    chk(rdata[0], 1'b1, "R8 write 0 no effect");
    host_wr(32'h0000_0001);
    chk(rdata[0], 1'b0, "R8 ack clears");
    chk(irq, 1'b0, "R11 irq drops");
    @(negedge clk); wr = 1'b1; wdata = 32'h1; msg_st = 1'b1;
    @(negedge clk); wr = 1'b0; wdata = '0; msg_st = 1'b0;
    chk(rdata[0], 1'b1, "R8 set wins over ack");
    host_wr(32'h0000_0088);   // interrupt enable off
    chk({rdata[0], irq}, 2'b10, "R11 masked");
    host_wr(32'h0000_0001);
  endtask

  task automatic t_reply_mode();
    host_wr(32'h0000_0098);   // auto reply on
    pulse(1, 0, 0, 0);
    chk(rdata[0], 1'b0, "R7 message ignored");
    pulse(0, 1, 0, 0);
    chk(rdata[0], 1'b1, "R7 reply-sent sets flag");
    host_wr(32'h0000_0001);
    chk(rdata[0], 1'b0, "R8 ack in reply mode");
  endtask

  task automatic t_pend_abort();
    host_wr(32'h0000_0002);
    chk(rdata[1], 1'b0, "R10 host cannot set");
    pulse(0, 0, 1, 0);
    chk({rdata[1], pnd}, 2'b11, "R10 pending set");
    host_wr(32'h0000_0002);
    chk(rdata[1], 1'b1, "R10 host write ignored");
    host_wr(32'h0000_0004);
    chk({rdata[2], abrt}, 2'b11, "R9 abort requested");
    pulse(0, 0, 0, 1);
    chk(rdata[2:1], 2'b00, "R9 done clears both");
    pulse(0, 0, 1, 0);
    pulse(0, 0, 0, 1);
    chk(rdata[2:1], 2'b00, "R9 won arbitration clears");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctl_gate();
    t_opt_gate();
    t_readback();
    t_len();
    t_msg_mode();
    t_ack();
    t_reply_mode();
    t_pend_abort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule